// File: doc/BRIEF.md
# GPIO Bank Event Interrupt Logic

This block watches a bank of already synchronized input lines and flags, per line, when a chosen event occurs. A 3-bit selector per line chooses the event type. The choices are a falling edge, a rising edge, either edge, a low level or a high level.

Every detected event sets a sticky bit in a status vector. A single read strobe clears that status vector.

A separate enable mask decides which pending bits may raise the bank's single interrupt request. Software changes the mask only through two write strobes, one that sets bits and one that clears them, so no read-modify-write of the mask is ever needed.

Top module: `gpio_evt_irq_bank`

## Requirements
- R1: While `rst` is high at a clock edge, the status and mask vectors become all zero after that edge, and `irq_o` is low.
- R2: Selector value 0 (falling edge) sets the line's status bit one cycle after a clock where the line was 1 on the previous edge and is 0 now.
- R3: Selector value 1 (rising edge) sets the status bit on a 0-to-1 change, sampled the same way.
- R4: Selector value 2 (both edges) sets the status bit on any change of the line between consecutive edges.
- R5: Selector value 3 (low level) sets the status bit on every clock where the line is 0. The bit is therefore pending again right after a read while the line stays low.
- R6: Selector value 4 (high level) sets the status bit on every clock where the line is 1.
- R7: Selector values 5, 6 and 7 never set a status bit.
- R8: A cycle with `en_wr` high ORs `en_data` into the mask. Mask bits not named in `en_data` keep their value, and the mask holds while no strobe is given.
- R9: A cycle with `dis_wr` high clears the mask bits named in `dis_data`. When both strobes name the same bit in one cycle, the bit ends up cleared.
- R10: `stat_q` shows the status during the cycle in which `stat_rd` is high, and the status is zero after that edge. The exception is that an event detected in that same cycle stays pending.
- R11: Status bits latch whether or not the line is enabled in the mask.
- R12: `irq_o` is high exactly when some bit is set in both `stat_q` and `mask_q`. It reacts in the same cycle as those registers.
- R13: No edge event is detected on the first clock after reset is released, whatever level the lines have.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | N_LINES | Synchronized line levels |
| evt_sel | input | 3*N_LINES | Event selector per line; line i uses bits [3i+2:3i] |
| en_wr | input | 1 | Mask set strobe |
| en_data | input | N_LINES | Mask bits to set |
| dis_wr | input | 1 | Mask clear strobe |
| dis_data | input | N_LINES | Mask bits to clear |
| stat_rd | input | 1 | Status read strobe, clears status |
| stat_q | output | N_LINES | Pending event status |
| mask_q | output | N_LINES | Interrupt enable mask |
| irq_o | output | 1 | Bank interrupt request |

## Verification
A wrong previous-sample or arming register would show up as a spurious or missing status bit on `stat_q` one clock after the offending edge. The clearest case is a ghost rising event right after reset.

A corrupted mask shows on `mask_q` at the next clock, and on `irq_o` in that same cycle if a bit is pending. A faulty clear-on-read path shows one clock after `stat_rd`, either as a lost same-cycle event or as stale bits that survive the read.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        EV_FALL = 3'd0,
        EV_RISE = 3'd1,
        EV_BOTH = 3'd2,
        EV_LOW  = 3'd3,
        EV_HIGH = 3'd4
    } evt_kind_e;

    typedef struct packed {
        logic armed;
        logic prev;
        logic cur;
    } line_smp_t;

    // Decide whether one line's sample pair matches its selected event.
    function automatic logic evt_match(logic [SEL_W-1:0] sel, line_smp_t s);
        logic hit;
        hit = 1'b0;
        case (sel)
            EV_FALL: hit = s.armed & s.prev & ~s.cur;
            EV_RISE: hit = s.armed & ~s.prev & s.cur;
            EV_BOTH: hit = s.armed & (s.prev ^ s.cur);
            EV_LOW:  hit = ~s.cur;
            EV_HIGH: hit = s.cur;
            default: hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
    import gpio_evt_pkg::*;
#(
    parameter int N_LINES = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_LINES-1:0]       line_in,
    input  logic [N_LINES*SEL_W-1:0] evt_sel,
    output logic [N_LINES-1:0]       evt_hit
);
    logic [N_LINES-1:0] prev_q;
    logic               armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            prev_q  <= line_in;
            armed_q <= 1'b1;
        end
    end

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        line_smp_t smp;
        always_comb begin
            smp.armed = armed_q;
            smp.prev  = prev_q[i];
            smp.cur   = line_in[i];
        end
        assign evt_hit[i] = evt_match(evt_sel[i*SEL_W +: SEL_W], smp);
    end
endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status #(
    parameter int N_LINES = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] evt_hit,
    input  logic               stat_rd,
    output logic [N_LINES-1:0] stat_q
);
    logic [N_LINES-1:0] keep;

    assign keep = stat_rd ? '0 : stat_q;

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= keep | evt_hit;
    end
endmodule

// File: rtl/gpio_evt_mask.sv
module gpio_evt_mask #(
    parameter int N_LINES = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en_wr,
    input  logic [N_LINES-1:0] en_data,
    input  logic               dis_wr,
    input  logic [N_LINES-1:0] dis_data,
    output logic [N_LINES-1:0] mask_q
);
    logic [N_LINES-1:0] set_v, clr_v;

    assign set_v = en_wr  ? en_data  : '0;
    assign clr_v = dis_wr ? dis_data : '0;

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= (mask_q | set_v) & ~clr_v;
    end
endmodule

// File: rtl/gpio_evt_irq_bank.sv
module gpio_evt_irq_bank
    import gpio_evt_pkg::*;
#(
    parameter int N_LINES = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_LINES-1:0]       line_in,
    input  logic [N_LINES*SEL_W-1:0] evt_sel,
    input  logic                     en_wr,
    input  logic [N_LINES-1:0]       en_data,
    input  logic                     dis_wr,
    input  logic [N_LINES-1:0]       dis_data,
    input  logic                     stat_rd,
    output logic [N_LINES-1:0]       stat_q,
    output logic [N_LINES-1:0]       mask_q,
    output logic                     irq_o
);
    logic [N_LINES-1:0] evt_hit;

    gpio_evt_detect #(.N_LINES(N_LINES)) u_detect (
        .clk     (clk),
        .rst     (rst),
        .line_in (line_in),
        .evt_sel (evt_sel),
        .evt_hit (evt_hit)
    );

    gpio_evt_status #(.N_LINES(N_LINES)) u_status (
        .clk     (clk),
        .rst     (rst),
        .evt_hit (evt_hit),
        .stat_rd (stat_rd),
        .stat_q  (stat_q)
    );

    gpio_evt_mask #(.N_LINES(N_LINES)) u_mask (
        .clk      (clk),
        .rst      (rst),
        .en_wr    (en_wr),
        .en_data  (en_data),
        .dis_wr   (dis_wr),
        .dis_data (dis_data),
        .mask_q   (mask_q)
    );

    assign irq_o = |(stat_q & mask_q);
endmodule

// File: rtl/gpio_evt_irq_chk.sv
module gpio_evt_irq_chk #(
    parameter int N_LINES = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               en_wr,
    input logic [N_LINES-1:0] en_data,
    input logic               dis_wr,
    input logic [N_LINES-1:0] dis_data,
    input logic               stat_rd,
    input logic [N_LINES-1:0] stat_q,
    input logic [N_LINES-1:0] mask_q,
    input logic               irq_o
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (stat_q == '0 && mask_q == '0));

    p_en_sets_r8: assert property (@(posedge clk) disable iff (rst)
        (en_wr && !dis_wr) |=> ((mask_q & $past(en_data)) == $past(en_data)));

    p_mask_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!en_wr && !dis_wr) |=> $stable(mask_q));

    p_dis_clears_r9: assert property (@(posedge clk) disable iff (rst)
        dis_wr |=> ((mask_q & $past(dis_data)) == '0));

    p_stat_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        !stat_rd |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    p_irq_no_mask_r12: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq_o);

    p_irq_no_stat_r12: assert property (@(posedge clk) disable iff (rst)
        (stat_q == '0) |-> !irq_o);
endmodule

bind gpio_evt_irq_bank gpio_evt_irq_chk #(.N_LINES(N_LINES)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .en_wr    (en_wr),
    .en_data  (en_data),
    .dis_wr   (dis_wr),
    .dis_data (dis_data),
    .stat_rd  (stat_rd),
    .stat_q   (stat_q),
    .mask_q   (mask_q),
    .irq_o    (irq_o)
);

// File: tb/gpio_evt_irq_bank_tb.sv
module gpio_evt_irq_bank_tb_top;
    localparam int N  = 32;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  line_d;
    logic [N*SW-1:0] sel_d;
    logic          en_wr_d, dis_wr_d, rd_d;
    logic [N-1:0]  en_d, dis_d;
    logic [N-1:0]  stat_q, mask_q;
    logic          irq_o;

    logic [N-1:0]  m_stat, m_mask, m_prev;
    logic          m_armed;
    int            errors = 0;
    int            checks = 0;
    bit            done = 0;

    always #5 clk = ~clk;

    gpio_evt_irq_bank #(.N_LINES(N)) dut_i (
        .clk(clk), .rst(rst), .line_in(line_d), .evt_sel(sel_d),
        .en_wr(en_wr_d), .en_data(en_d), .dis_wr(dis_wr_d), .dis_data(dis_d),
        .stat_rd(rd_d), .stat_q(stat_q), .mask_q(mask_q), .irq_o(irq_o)
    );

    // Event rule per line, written from the selector encoding in R2..R7, R13.
    function automatic logic ev_ref(int sel, logic cur, logic prv, logic armed);
        if (sel == 0) return armed && prv && !cur;
        if (sel == 1) return armed && !prv && cur;
        if (sel == 2) return armed && (prv != cur);
        if (sel == 3) return !cur;
        if (sel == 4) return cur;
        return 1'b0;
    endfunction

    function automatic logic [N*SW-1:0] all_sel(int k);
        logic [N*SW-1:0] v;
        for (int i = 0; i < N; i++) v[i*SW +: SW] = k[SW-1:0];
        return v;
    endfunction

    task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag);
        logic [N-1:0] ev;
        @(posedge clk);
        if (rst) begin
            m_stat = '0; m_mask = '0; m_prev = '0; m_armed = 1'b0;
        end else begin
            for (int i = 0; i < N; i++)
                ev[i] = ev_ref(int'(sel_d[i*SW +: SW]), line_d[i], m_prev[i], m_armed);
            m_stat  = (rd_d ? '0 : m_stat) | ev;
            m_mask  = (m_mask | (en_wr_d ? en_d : '0)) & ~(dis_wr_d ? dis_d : '0);
            m_prev  = line_d;
            m_armed = 1'b1;
        end
        @(negedge clk);
        chk(tag, stat_q, m_stat, "status");
        chk(tag, mask_q, m_mask, "mask");
        chk("R12", {{(N-1){1'b0}}, irq_o}, {{(N-1){1'b0}}, |(m_stat & m_mask)}, "irq");
        en_wr_d = 1'b0; dis_wr_d = 1'b0; rd_d = 1'b0;
    endtask

    task automatic clear_stat();
        sel_d = all_sel(6);
        rd_d = 1'b1; step("R7");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; line_d = '1; sel_d = all_sel(1);
        en_wr_d = 0; dis_wr_d = 0; rd_d = 0; en_d = '0; dis_d = '0;
        m_stat = '0; m_mask = '0; m_prev = '0; m_armed = 0;
        @(negedge clk);
        repeat (3) step("R1");
        // R13: lines high at release with rising select: no ghost edge
        rst = 1'b0;
        step("R13"); step("R13");

        // R8 / R9 mask strobes
        en_wr_d = 1; en_d = 32'h0000_00FF; step("R8");
        en_wr_d = 1; en_d = 32'h00F0_0000; step("R8");
        step("R8");
        dis_wr_d = 1; dis_d = 32'h0000_000F; step("R9");
        en_wr_d = 1; en_d = 32'h0000_0100; dis_wr_d = 1; dis_d = 32'h0000_0100; step("R9");

        // R2 falling
        sel_d = all_sel(0); line_d = 32'hFFFF_FFFF; step("R2");
        line_d = 32'h0000_FFFF; step("R2"); step("R2");
        clear_stat();
        // R3 rising
        sel_d = all_sel(1); line_d = 32'h0000_0000; step("R3");
        line_d = 32'hA5A5_0000; step("R3");
        clear_stat();
        // R4 both
        sel_d = all_sel(2); line_d = 32'h0F0F_0F0F; step("R4");
        line_d = 32'h00FF_00FF; step("R4");
        clear_stat();
        // R5 low level re-pends after a read
        sel_d = all_sel(3); line_d = 32'h0000_FFFF; step("R5");
        rd_d = 1; step("R5"); step("R5");
        clear_stat();
        // R6 high level
        sel_d = all_sel(4); line_d = 32'h1234_5678; step("R6");
        clear_stat();
        // R7 reserved selectors
        for (int k = 5; k < 8; k++) begin
            sel_d = all_sel(k);
            line_d = 32'hFFFF_FFFF; step("R7");
            line_d = 32'h0000_0000; step("R7");
        end
        // R10 read in the same cycle as a new event keeps it
        sel_d = all_sel(1); line_d = '0; step("R10");
        line_d = 32'h0000_0001; step("R10");
        line_d = 32'h0000_0003; rd_d = 1; step("R10");
        rd_d = 1; step("R10");
        // R11 status latches with mask cleared
        dis_wr_d = 1; dis_d = '1; step("R11");
        sel_d = all_sel(4); line_d = 32'h8000_0000; step("R11");
        en_wr_d = 1; en_d = 32'h8000_0000; step("R12");
        clear_stat();

        // R12 constrained random traffic
        for (int n = 0; n < 1500; n++) begin
            if (n % 16 == 0)
                for (int i = 0; i < N; i++) sel_d[i*SW +: SW] = SW'($urandom % 8);
            line_d = $urandom;
            if ($urandom % 4 == 0) begin en_wr_d = 1; en_d = $urandom; end
            if ($urandom % 4 == 0) begin dis_wr_d = 1; dis_d = $urandom; end
            if ($urandom % 3 == 0) rd_d = 1;
            step("R12");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule